// File: doc/BRIEF.md
# IDE Device Register Interface

This block is the device end of a parallel disk-style host bus. It does not decode raw pin timing. It samples the host's strobes on its own clock and turns each completed access into one internal action. Two active-low chip selects open two register spaces. The primary space holds the data port, six byte-wide parameter registers, and the status/command location. The secondary space holds the alternate status and device-control location. The data port carries full 16-bit words. Every other location uses only the low byte.

The data port connects to two word FIFOs on the back-end side:
- Words that the back end pushes are read by the host, either by programmed reads or by Multiword DMA.
- Words that the host writes are popped by the back end.

The block also does the following:
- Runs the DMA request/acknowledge handshake.
- Drives an active-low word-transfer indicator.
- Latches an interrupt request raised by the back end, then clears or masks it according to host register activity.
- Passes each byte written to the command location to the back end as a one-cycle strobe.

Top module: `ide_regif`

## Requirements
- R1: Under the primary chip select alone (`hostCs0N`=0, `hostCs1N`=1), addresses 1 to 6 are byte registers. A write stores `hostDataIn[7:0]`. A read returns the stored byte on `hostDataOut[7:0]` with bits 15:8 at zero.
- R2: Under the secondary chip select alone, address 6 reads as alternate status and writes the device-control byte. Any other secondary address reads as 0 and ignores writes. An access with both chip selects asserted, or with neither, changes no register.
- R3: Primary address 0 is the 16-bit data port. A read returns the oldest word of the device-to-host FIFO and removes it when the read strobe ends. A read of an empty FIFO returns 0x0000. A write pushes the full `hostDataIn` word into the host-to-device FIFO.
- R4: A write takes effect only on the rising edge of `hostWrN`. Nothing is stored while the strobe is still low.
- R5: Primary address 7 reads as the status byte: bit 7 = `beBusy`, bit 6 = not `beBusy`, bit 3 = the device-to-host FIFO holds a word, all other bits 0. A write there raises `beCmdStrobe` for one cycle with the byte on `beCmdByte`.
- R6: A `beIrq` pulse sets a pending interrupt, shown on the active-high `intrq`. A completed read of the status byte clears it. A read of alternate status leaves it set.
- R7: Device-control bit 1 set to 1 forces `intrq` low without discarding the pending interrupt. Clearing the bit shows it again.
- R8: While `beDmaActive` is high, `dmarq` rises when the device can move a word: the device-to-host FIFO is not empty when `beDmaToHost`=1, or the host-to-device FIFO is not full when it is 0. `dmarq` then stays high until `hostDmackN` goes low and falls one cycle later. After acknowledge is released it rises again only if another word can move. With `beDmaActive` low, `dmarq` is low.
- R9: With DMA active and `hostDmackN` low, each read or write strobe moves one 16-bit data word whatever the chip selects and address show.
- R10: With `beDmaActive` low, `hostDmackN` is ignored at any level, unknown included, and accesses decode by chip select alone.
- R11: `iocs16N` is low while the selected target is the data port or a valid DMA acknowledge, and high for byte registers.
- R12: `hostDataOe` is high only while `hostRdN` is low and a register space or DMA acknowledge is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host strobes are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCs0N | input | 1 | Primary register space select, active low |
| hostCs1N | input | 1 | Secondary register space select, active low |
| hostAddr | input | 3 | Register address within the selected space |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low, committed on its rising edge |
| hostDmackN | input | 1 | DMA acknowledge, active low |
| hostDataIn | input | 16 | Write data from the host |
| hostDataOut | output | 16 | Read data to the host, zero when not driven |
| hostDataOe | output | 1 | Read data valid / bus drive enable |
| dmarq | output | 1 | DMA request |
| iocs16N | output | 1 | Word-transfer indicator, active low |
| intrq | output | 1 | Interrupt request, active high |
| beBusy | input | 1 | Back end busy, shown in status |
| beIrq | input | 1 | One-cycle pulse that sets the pending interrupt |
| beDmaActive | input | 1 | A DMA transfer is in progress |
| beDmaToHost | input | 1 | DMA direction: 1 device-to-host, 0 host-to-device |
| bePushValid | input | 1 | Back end offers a word for the host |
| bePushData | input | 16 | Word offered for the host |
| bePushReady | output | 1 | Device-to-host FIFO has room |
| bePopValid | output | 1 | Host-to-device FIFO holds a word |
| bePopData | output | 16 | Oldest host-written word |
| bePopReady | input | 1 | Back end takes the oldest host-written word |
| beCmdStrobe | output | 1 | One-cycle pulse on a command write |
| beCmdByte | output | 8 | Command byte written by the host |

## Verification
Several rules are checked on every clock:
- `dmarq` is off whenever DMA is inactive, and drops the cycle after an acknowledge.
- Byte-register reads never carry a nonzero upper byte.
- The data drive enable never asserts outside a read strobe.
- A valid acknowledge always signals a word transfer.
- The pending interrupt only ever rises from a back-end pulse, and a completed status read leaves it low.

The scenarios themselves show the parts that depend on history and data values:
- Register write-back and the isolation of the two spaces.
- FIFO ordering through the data port and through DMA.
- Commit only at the trailing write edge.
- The mask hiding an interrupt that remains pending.
- The acknowledge being ignored, even when unknown, while no DMA is running.

// File: rtl/ide_regif_pkg.sv
package ide_regif_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int TF_FIRST = 1;
  localparam int TF_LAST  = 6;

  localparam logic [ADDR_W-1:0] ADDR_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd7;
  localparam logic [ADDR_W-1:0] ADDR_ALT    = 3'd6;

  localparam int CTRL_MASK_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TASK,
    SEL_STATUS,
    SEL_DATA,
    SEL_ALT,
    SEL_CS1_OTHER
  } selKind_t;

  typedef struct packed {
    logic              tfWrite;
    logic              cmdWrite;
    logic              ctrlWrite;
    logic              dataPush;
    logic              dataPop;
    logic              irqClear;
    selKind_t          rdSel;
    logic [ADDR_W-1:0] idx;
  } strobes_t;
endpackage

// File: rtl/ide_word_fifo.sv
module ide_word_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/ide_regif_ctrl.sv
module ide_regif_ctrl
  import ide_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs0N,
  input  logic              hostCs1N,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostDmackN,
  input  logic              beDmaActive,
  input  logic              beDmaToHost,
  input  logic              rdFifoEmpty,
  input  logic              wrFifoFull,
  output strobes_t          stb,
  output logic              dataOe,
  output logic              iocs16N,
  output logic              dmarq
);
  logic rdPrev, wrPrev;
  logic rdEnd, wrEnd;
  logic dmackOn, pioCs0, pioCs1, isData, dmaReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      rdPrev <= hostRdN;
      wrPrev <= hostWrN;
    end
  end

  assign rdEnd = !rdPrev && hostRdN;
  assign wrEnd = !wrPrev && hostWrN;

  // Acknowledge only counts while a transfer is running; the AND with
  // the active flag keeps an unknown acknowledge from leaking through.
  assign dmackOn = beDmaActive && (hostDmackN == 1'b0);
  assign pioCs0  = !dmackOn && !hostCs0N && hostCs1N;
  assign pioCs1  = !dmackOn && hostCs0N && !hostCs1N;
  assign isData  = dmackOn || (pioCs0 && hostAddr == ADDR_DATA);

  always_comb begin
    stb           = '0;
    stb.idx       = hostAddr;
    stb.tfWrite   = wrEnd && pioCs0 && hostAddr != ADDR_DATA && hostAddr != ADDR_STATUS;
    stb.cmdWrite  = wrEnd && pioCs0 && hostAddr == ADDR_STATUS;
    stb.ctrlWrite = wrEnd && pioCs1 && hostAddr == ADDR_ALT;
    stb.dataPush  = wrEnd && isData;
    stb.dataPop   = rdEnd && isData;
    stb.irqClear  = rdEnd && pioCs0 && hostAddr == ADDR_STATUS;
    if (isData)      stb.rdSel = SEL_DATA;
    else if (pioCs0) stb.rdSel = (hostAddr == ADDR_STATUS) ? SEL_STATUS : SEL_TASK;
    else if (pioCs1) stb.rdSel = (hostAddr == ADDR_ALT) ? SEL_ALT : SEL_CS1_OTHER;
    else             stb.rdSel = SEL_NONE;
  end

  assign dataOe  = !hostRdN && (stb.rdSel != SEL_NONE);
  assign iocs16N = !isData;

  assign dmaReady = beDmaToHost ? !rdFifoEmpty : !wrFifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dmarq <= 1'b0;
    else if (beDmaActive) dmarq <= dmaReady && hostDmackN;
    else                  dmarq <= 1'b0;
  end
endmodule

// File: rtl/ide_regif_dpath.sv
module ide_regif_dpath
  import ide_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              beBusy,
  input  logic              beIrq,
  input  logic              bePushValid,
  input  logic [WORD_W-1:0] bePushData,
  output logic              bePushReady,
  output logic              bePopValid,
  output logic [WORD_W-1:0] bePopData,
  input  logic              bePopReady,
  output logic              beCmdStrobe,
  output logic [BYTE_W-1:0] beCmdByte,
  output logic [WORD_W-1:0] rdData,
  output logic              intrq,
  output logic              rdFifoEmpty,
  output logic              wrFifoFull
);
  logic [BYTE_W-1:0] tfReg [TF_FIRST:TF_LAST];
  logic [BYTE_W-1:0] tfByte, statusByte;
  logic [WORD_W-1:0] rdHead;
  logic              rdFifoFull, wrFifoEmpty;
  logic              irqPending, irqMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = TF_FIRST; i <= TF_LAST; i++) tfReg[i] <= '0;
    end else if (stb.tfWrite) begin
      for (int i = TF_FIRST; i <= TF_LAST; i++)
        if (stb.idx == ADDR_W'(i)) tfReg[i] <= wrData[BYTE_W-1:0];
    end
  end

  always_comb begin
    tfByte = '0;
    for (int i = TF_FIRST; i <= TF_LAST; i++)
      if (stb.idx == ADDR_W'(i)) tfByte = tfReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending  <= 1'b0;
      irqMask     <= 1'b0;
      beCmdStrobe <= 1'b0;
      beCmdByte   <= '0;
    end else begin
      irqPending  <= (irqPending && !stb.irqClear) || beIrq;
      if (stb.ctrlWrite) irqMask <= wrData[CTRL_MASK_BIT];
      beCmdStrobe <= stb.cmdWrite;
      if (stb.cmdWrite) beCmdByte <= wrData[BYTE_W-1:0];
    end
  end

  assign intrq = irqPending && !irqMask;

  ide_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) uToHost (
    .clk(clk), .rstN(rstN),
    .push(bePushValid), .pushData(bePushData), .pop(stb.dataPop),
    .head(rdHead), .empty(rdFifoEmpty), .full(rdFifoFull)
  );

  ide_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) uFromHost (
    .clk(clk), .rstN(rstN),
    .push(stb.dataPush), .pushData(wrData), .pop(bePopReady),
    .head(bePopData), .empty(wrFifoEmpty), .full(wrFifoFull)
  );

  assign bePushReady = !rdFifoFull;
  assign bePopValid  = !wrFifoEmpty;

  assign statusByte = {beBusy, !beBusy, 2'b00, !rdFifoEmpty, 3'b000};

  always_comb begin
    unique case (stb.rdSel)
      SEL_DATA:   rdData = rdFifoEmpty ? '0 : rdHead;
      SEL_TASK:   rdData = {{(WORD_W-BYTE_W){1'b0}}, tfByte};
      SEL_STATUS,
      SEL_ALT:    rdData = {{(WORD_W-BYTE_W){1'b0}}, statusByte};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/ide_regif.sv
module ide_regif
  import ide_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs0N,
  input  logic              hostCs1N,
  input  logic [2:0]        hostAddr,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostDmackN,
  input  logic [15:0]       hostDataIn,
  output logic [15:0]       hostDataOut,
  output logic              hostDataOe,
  output logic              dmarq,
  output logic              iocs16N,
  output logic              intrq,
  input  logic              beBusy,
  input  logic              beIrq,
  input  logic              beDmaActive,
  input  logic              beDmaToHost,
  input  logic              bePushValid,
  input  logic [15:0]       bePushData,
  output logic              bePushReady,
  output logic              bePopValid,
  output logic [15:0]       bePopData,
  input  logic              bePopReady,
  output logic              beCmdStrobe,
  output logic [7:0]        beCmdByte
);
  strobes_t          stb;
  logic              dataOe, rdFifoEmpty, wrFifoFull;
  logic [WORD_W-1:0] rdData;

  ide_regif_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .hostCs0N(hostCs0N), .hostCs1N(hostCs1N), .hostAddr(hostAddr),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostDmackN(hostDmackN),
    .beDmaActive(beDmaActive), .beDmaToHost(beDmaToHost),
    .rdFifoEmpty(rdFifoEmpty), .wrFifoFull(wrFifoFull),
    .stb(stb), .dataOe(dataOe), .iocs16N(iocs16N), .dmarq(dmarq)
  );

  ide_regif_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostDataIn),
    .beBusy(beBusy), .beIrq(beIrq),
    .bePushValid(bePushValid), .bePushData(bePushData), .bePushReady(bePushReady),
    .bePopValid(bePopValid), .bePopData(bePopData), .bePopReady(bePopReady),
    .beCmdStrobe(beCmdStrobe), .beCmdByte(beCmdByte),
    .rdData(rdData), .intrq(intrq),
    .rdFifoEmpty(rdFifoEmpty), .wrFifoFull(wrFifoFull)
  );

  assign hostDataOe  = dataOe;
  assign hostDataOut = dataOe ? rdData : '0;
endmodule

// File: rtl/ide_regif_chk.sv
module ide_regif_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostCs0N,
  input logic        hostCs1N,
  input logic [2:0]  hostAddr,
  input logic        hostRdN,
  input logic        hostDmackN,
  input logic [15:0] hostDataOut,
  input logic        hostDataOe,
  input logic        dmarq,
  input logic        iocs16N,
  input logic        intrq,
  input logic        beIrq,
  input logic        beDmaActive,
  input logic        irqPend
);
  AST_DMARQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !beDmaActive |=> !dmarq); // R8

  AST_DMARQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    dmarq && beDmaActive && !hostDmackN |=> !dmarq); // R8

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe && iocs16N |-> hostDataOut[15:8] == 8'h00); // R1

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    hostRdN |-> !hostDataOe); // R12

  AST_DMA_WORD: assert property (@(posedge clk) disable iff (!rstN)
    beDmaActive && !hostDmackN |-> !iocs16N); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(beIrq)); // R6

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRdN) && !hostCs0N && hostCs1N && hostAddr == 3'd7 && !beIrq
      && !(beDmaActive && !hostDmackN) |=> !intrq); // R6
endmodule

bind ide_regif ide_regif_chk uChk (
  .clk(clk), .rstN(rstN), .hostCs0N(hostCs0N), .hostCs1N(hostCs1N),
  .hostAddr(hostAddr), .hostRdN(hostRdN), .hostDmackN(hostDmackN),
  .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .dmarq(dmarq),
  .iocs16N(iocs16N), .intrq(intrq), .beIrq(beIrq), .beDmaActive(beDmaActive),
  .irqPend(uDp.irqPending)
);

// File: tb/tb_ide_regif.sv
module tb_ide_regif;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCs0N = 1'b1, hostCs1N = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic        hostDmackN = 1'b1;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe, dmarq, iocs16N, intrq;
  logic        beBusy = 1'b0, beIrq = 1'b0, beDmaActive = 1'b0, beDmaToHost = 1'b0;
  logic        bePushValid = 1'b0, bePopReady = 1'b0;
  logic [15:0] bePushData = '0;
  logic        bePushReady, bePopValid, beCmdStrobe;
  logic [15:0] bePopData;
  logic [7:0]  beCmdByte;

  int compared = 0, mismatched = 0, cmdCount = 0;
  logic [7:0] lastCmd = '0;
  bit done = 0;
  string       tagQ[$];
  logic [15:0] expQ[$], actQ[$];

  always #5 clk = ~clk;

  ide_regif dut (.*);

  always @(negedge clk) if (beCmdStrobe) begin cmdCount++; lastCmd = beCmdByte; end

  // monitor: pops scoreboard entries and compares
  initial forever begin
    @(posedge clk);
    while (actQ.size() > 0) begin
      string t;
      logic [15:0] e, a;
      t = tagQ.pop_front(); e = expQ.pop_front(); a = actQ.pop_front();
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] exp, input logic [15:0] act);
    tagQ.push_back(tag); expQ.push_back(exp); actQ.push_back(act);
  endtask

  task automatic busRead(input logic c0, input logic c1, input logic [2:0] a,
                         input logic [15:0] exp, input logic expIo, input string tag);
    @(negedge clk) hostCs0N = c0; hostCs1N = c1; hostAddr = a; hostRdN = 1'b0;
    @(negedge clk) check(tag, exp, hostDataOut);
    check({tag, " iocs16N"}, {15'd0, expIo}, {15'd0, iocs16N});
    check({tag, " R12 oe"}, 16'd1, {15'd0, hostDataOe});
    hostRdN = 1'b1;
    @(negedge clk) hostCs0N = 1'b1; hostCs1N = 1'b1;
  endtask

  task automatic busWrite(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk) hostCs0N = c0; hostCs1N = c1; hostAddr = a; hostDataIn = d; hostWrN = 1'b0;
    @(negedge clk);
    @(negedge clk) hostWrN = 1'b1;
    @(negedge clk) hostCs0N = 1'b1; hostCs1N = 1'b1;
  endtask

  task automatic bePush(input logic [15:0] d);
    @(negedge clk) bePushValid = 1'b1; bePushData = d;
    @(negedge clk) bePushValid = 1'b0;
  endtask

  task automatic bePop();
    @(negedge clk) bePopReady = 1'b1;
    @(negedge clk) bePopReady = 1'b0;
  endtask

  task automatic irqPulse();
    @(negedge clk) beIrq = 1'b1;
    @(negedge clk) beIrq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset intrq", 16'd0, {15'd0, intrq});
    check("reset R8 dmarq", 16'd0, {15'd0, dmarq});
    check("reset R11 iocs16N", 16'd1, {15'd0, iocs16N});
    check("reset R12 oe", 16'd0, {15'd0, hostDataOe});

    // R1: byte registers 1..6
    for (int i = 1; i <= 6; i++) busWrite(0, 1, 3'(i), {8'hA5, 8'(8'h10 + i)});
    for (int i = 1; i <= 6; i++) busRead(0, 1, 3'(i), {8'h00, 8'(8'h10 + i)}, 1'b1, "R1 readback");

    // R2: secondary space and illegal selects
    busRead(1, 0, 3'd6, 16'h0040, 1'b1, "R2 alt status");
    busRead(1, 0, 3'd3, 16'h0000, 1'b1, "R2 other secondary");
    busWrite(1, 0, 3'd2, 16'h0055);
    busRead(0, 1, 3'd2, 16'h0012, 1'b1, "R2 secondary write ignored");
    busWrite(0, 0, 3'd1, 16'h0077);
    busRead(0, 1, 3'd1, 16'h0011, 1'b1, "R2 both selects ignored");

    // R12: strobe with nothing selected
    @(negedge clk) hostRdN = 1'b0;
    @(negedge clk) check("R12 no select oe", 16'd0, {15'd0, hostDataOe});
    hostRdN = 1'b1;

    // R3 / R5: data port and status
    bePush(16'h1234); bePush(16'hBEEF);
    busRead(0, 1, 3'd7, 16'h0048, 1'b1, "R5 status drq");
    busRead(0, 1, 3'd0, 16'h1234, 1'b0, "R3 first word");
    busRead(0, 1, 3'd0, 16'hBEEF, 1'b0, "R3 second word");
    busRead(0, 1, 3'd0, 16'h0000, 1'b0, "R3 empty read");
    busWrite(0, 1, 3'd0, 16'hCAFE);
    @(negedge clk) check("R3 pushed valid", 16'd1, {15'd0, bePopValid});
    check("R3 pushed word", 16'hCAFE, bePopData);
    bePop();

    // R4: no commit while strobe low
    @(negedge clk) hostCs0N = 1'b0; hostAddr = 3'd0; hostDataIn = 16'h5A5A; hostWrN = 1'b0;
    @(negedge clk);
    @(negedge clk) check("R4 held low", 16'd0, {15'd0, bePopValid});
    hostWrN = 1'b1;
    @(negedge clk) check("R4 after rise valid", 16'd1, {15'd0, bePopValid});
    check("R4 after rise data", 16'h5A5A, bePopData);
    hostCs0N = 1'b1;
    bePop();

    // R5: busy and command strobe
    @(negedge clk) beBusy = 1'b1;
    busRead(0, 1, 3'd7, 16'h0080, 1'b1, "R5 busy");
    @(negedge clk) beBusy = 1'b0;
    busWrite(0, 1, 3'd7, 16'h00EC);
    @(negedge clk) check("R5 cmd count", 16'd1, 16'(cmdCount));
    check("R5 cmd byte", 16'h00EC, {8'h00, lastCmd});

    // R6: interrupt set and clear
    irqPulse();
    check("R6 set", 16'd1, {15'd0, intrq});
    busRead(1, 0, 3'd6, 16'h0040, 1'b1, "R6 alt read");
    check("R6 alt keeps", 16'd1, {15'd0, intrq});
    busRead(0, 1, 3'd7, 16'h0040, 1'b1, "R6 status read");
    check("R6 status clears", 16'd0, {15'd0, intrq});

    // R7: mask
    busWrite(1, 0, 3'd6, 16'h0002);
    irqPulse();
    check("R7 masked", 16'd0, {15'd0, intrq});
    busWrite(1, 0, 3'd6, 16'h0000);
    @(negedge clk) check("R7 unmasked pending", 16'd1, {15'd0, intrq});
    busRead(0, 1, 3'd7, 16'h0040, 1'b1, "R7 clear read");

    // R8 / R9: DMA toward host
    beDmaToHost = 1'b1;
    bePush(16'h1111); bePush(16'h2222);
    @(negedge clk) beDmaActive = 1'b1;
    @(negedge clk) check("R8 request", 16'd1, {15'd0, dmarq});
    repeat (3) @(negedge clk);
    check("R8 held", 16'd1, {15'd0, dmarq});
    hostDmackN = 1'b0;
    @(negedge clk) check("R8 drop on ack", 16'd0, {15'd0, dmarq});
    busRead(1, 1, 3'd0, 16'h1111, 1'b0, "R9 dma word");
    hostDmackN = 1'b1;
    @(negedge clk) check("R8 re-request", 16'd1, {15'd0, dmarq});
    hostDmackN = 1'b0;
    busRead(0, 1, 3'd3, 16'h2222, 1'b0, "R9 selects ignored");
    hostDmackN = 1'b1;
    @(negedge clk);
    @(negedge clk) check("R8 no more data", 16'd0, {15'd0, dmarq});
    busRead(0, 1, 3'd3, 16'h0013, 1'b1, "R9 tf untouched");

    // R8 / R9: DMA from host
    beDmaToHost = 1'b0;
    @(negedge clk);
    @(negedge clk) check("R8 write request", 16'd1, {15'd0, dmarq});
    hostDmackN = 1'b0;
    busWrite(1, 1, 3'd5, 16'h7777);
    hostDmackN = 1'b1;
    @(negedge clk) check("R9 dma write", 16'h7777, bePopData);
    bePop();
    @(negedge clk) beDmaActive = 1'b0;
    @(negedge clk) check("R8 inactive", 16'd0, {15'd0, dmarq});

    // R10: acknowledge ignored without DMA
    hostDmackN = 1'bx;
    bePush(16'h4444);
    busRead(0, 1, 3'd0, 16'h4444, 1'b0, "R10 unknown ack");
    check("R10 no request", 16'd0, {15'd0, dmarq});
    hostDmackN = 1'b0;
    busWrite(0, 1, 3'd1, 16'h003C);
    busRead(0, 1, 3'd1, 16'h003C, 1'b1, "R10 low ack decode");
    check("R10 no push", 16'd0, {15'd0, bePopValid});
    hostDmackN = 1'b1;

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule